// File: doc/BRIEF.md
# I2C Slave Bus Front End

This block sits between the raw SCL and SDA pins and a slave protocol engine, and runs entirely on the system clock. Each line passes through a synchronizer and then a persistence filter. The filter drops any pulse shorter than a programmed number of clock cycles. The filtered lines are shown to the engine as a set of one-cycle events:
- start of a transfer
- start repeated inside a transfer, which tells the engine to clear its bit counter
- end of a transfer
- one strobe for each data bit, sampled on the rising SCL edge

A level output reports that a transfer is open. Another level output reports that both lines have stayed released long enough for the bus to count as free.

On the output side the engine asks for a bit level with an enable and a value. The block turns that request into an open-drain pull-down enable. The enable can only pull SDA low and is never driven high. It changes only while SCL is low, and only after a minimum hold delay has passed since the last falling SCL edge. As a result the slave cannot create a false START or STOP.

All time constants are given in nanoseconds with the system clock period and are converted to cycle counts when the block is elaborated.

Top module: `i2c_bus_front`

## Requirements
- R1: When filtered SDA falls while filtered SCL stays high, `start_o` pulses for one cycle and `bus_busy_o` is set from the next cycle.
- R2: When filtered SDA rises while filtered SCL stays high, `stop_o` pulses for one cycle and `bus_busy_o` clears from the next cycle.
- R3: `rep_start_o` pulses together with `start_o` only when the START arrives while `bus_busy_o` is already set. It stays low for a START from the idle bus.
- R4: While `bus_busy_o` is set, every rising edge of filtered SCL gives one `bit_valid_o` pulse, and `bit_o` carries the filtered SDA level at that moment. An MSB-first byte shifts in as eight strobes.
- R5: A pulse on either line that lasts fewer than FILT_CYC = ceil(SPIKE_NS/CLK_PERIOD_NS) clock cycles does not reach the filtered lines. It therefore gives no start, stop or bit event and leaves `bus_free_o` unchanged.
- R6: `bus_free_o` is low after reset. It rises once both filtered lines have been high with no open transfer for IDLE_CYC = ceil(IDLE_NS/CLK_PERIOD_NS) cycles, and it drops in the cycle after a START.
- R7: `sda_oe_o` never changes while filtered SCL is high during a transfer. After a raw SCL fall it keeps its old value for FILT_CYC+HOLD_CYC+3 cycles, where HOLD_CYC = ceil(HOLD_NS/CLK_PERIOD_NS), and it takes the new value in the following cycle.
- R8: The value applied to `sda_oe_o` is `tx_en_i & ~tx_bit_i`, with 1 meaning pull SDA low. A request for a high bit leaves the line released.
- R9: Outside an open transfer, `sda_oe_o` is held at 0 whatever the transmit request.
- R10: During reset and right after it, `sda_oe_o`, `start_o`, `stop_o`, `bit_valid_o`, `bus_busy_o` and `bus_free_o` are 0, and `scl_o` and `sda_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| tx_en_i | input | 1 | Engine wants to place a bit on SDA |
| tx_bit_i | input | 1 | Bit level requested (0 pulls low) |
| sda_oe_o | output | 1 | Open-drain pull-down enable for SDA |
| scl_o | output | 1 | Filtered SCL |
| sda_o | output | 1 | Filtered SDA |
| start_o | output | 1 | START seen, one cycle |
| rep_start_o | output | 1 | START seen inside a transfer, one cycle |
| stop_o | output | 1 | STOP seen, one cycle |
| bit_valid_o | output | 1 | Data bit strobe on rising SCL |
| bit_o | output | 1 | Sampled data bit |
| bus_busy_o | output | 1 | Transfer open between START and STOP |
| bus_free_o | output | 1 | Bus idle for the free time |

## Verification
The bench builds the block with its default settings: an 8 ns clock, a 50 ns spike limit, a 300 ns hold and a 1300 ns free time. These give 7, 38 and 163 cycles. With those values the bench checks the pull-down enable on the exact cycle on each side of the hold boundary. It also sends spikes one cycle shorter than the filter on both lines, both during idle and inside a transfer, and waits out the full free time after reset and after STOP. The SCL phases are 60 cycles long, so the full input delay plus the hold delay fits inside one low phase.

// File: rtl/i2c_fe_pkg.sv
`timescale 1ns/1ps
package i2c_fe_pkg;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic bit_vld;
    logic bit_val;
  } bus_evt_t;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/i2c_spike_filter.sv
`timescale 1ns/1ps
module i2c_spike_filter #(
  parameter int unsigned FILT_CYC    = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;
  logic                   samp;

  assign samp   = sync_q[SYNC_STAGES-1];
  assign line_o = filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (samp == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYC - 1)) begin
        // level persisted for FILT_CYC samples
        filt_q <= samp;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
`timescale 1ns/1ps
module i2c_cond_detect
  import i2c_fe_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 163
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o,
  output logic     busy_o,
  output logic     free_o
);
  localparam int unsigned IW = $clog2(IDLE_CYC + 1);

  logic          prev_scl_q, prev_sda_q, busy_q;
  logic [IW-1:0] idle_q;
  logic          start, stop, rise;

  assign start = scl_i & prev_scl_q & prev_sda_q & ~sda_i;
  assign stop  = scl_i & prev_scl_q & ~prev_sda_q & sda_i;
  assign rise  = scl_i & ~prev_scl_q;

  assign evt_o.start   = start;
  assign evt_o.rstart  = start & busy_q;
  assign evt_o.stop    = stop;
  assign evt_o.bit_vld = rise & busy_q;
  assign evt_o.bit_val = sda_i;

  assign busy_o = busy_q;
  assign free_o = (idle_q == IW'(IDLE_CYC)) & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_scl_q <= 1'b1;
      prev_sda_q <= 1'b1;
      busy_q     <= 1'b0;
      idle_q     <= '0;
    end else begin
      prev_scl_q <= scl_i;
      prev_sda_q <= sda_i;
      if (start)     busy_q <= 1'b1;
      else if (stop) busy_q <= 1'b0;
      if (busy_q | start | ~scl_i | ~sda_i) idle_q <= '0;
      else if (idle_q != IW'(IDLE_CYC))     idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_sda_hold_drv.sv
`timescale 1ns/1ps
module i2c_sda_hold_drv #(
  parameter int unsigned HOLD_CYC = 38
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic busy_i,
  input  logic tx_en_i,
  input  logic tx_bit_i,
  output logic sda_oe_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 2);

  logic          prev_scl_q, oe_q, fall, want;
  logic [HW-1:0] hold_q;

  assign fall     = prev_scl_q & ~scl_i;
  assign want     = tx_en_i & ~tx_bit_i;
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_scl_q <= 1'b1;
      hold_q     <= '0;
      oe_q       <= 1'b0;
    end else begin
      prev_scl_q <= scl_i;
      if (fall)               hold_q <= HW'(HOLD_CYC);
      else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
      if (!busy_i)                                  oe_q <= 1'b0;
      else if (!fall && hold_q == '0 && !scl_i)     oe_q <= want;
    end
  end
endmodule

// File: rtl/i2c_bus_front.sv
`timescale 1ns/1ps
module i2c_bus_front
  import i2c_fe_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned SPIKE_NS      = 50,
  parameter int unsigned HOLD_NS       = 300,
  parameter int unsigned IDLE_NS       = 1300,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tx_en_i,
  input  logic tx_bit_i,
  output logic sda_oe_o,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic rep_start_o,
  output logic stop_o,
  output logic bit_valid_o,
  output logic bit_o,
  output logic bus_busy_o,
  output logic bus_free_o
);
  localparam int unsigned FILT_CYC = ns_to_cyc(SPIKE_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned IDLE_CYC = ns_to_cyc(IDLE_NS, CLK_PERIOD_NS);

  logic [1:0] raw, filt;
  bus_evt_t   evt;
  logic       busy;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_spike_filter #(
      .FILT_CYC   (FILT_CYC),
      .SYNC_STAGES(SYNC_STAGES)
    ) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  i2c_cond_detect #(.IDLE_CYC(IDLE_CYC)) i_det (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (filt[1]),
    .sda_i (filt[0]),
    .evt_o (evt),
    .busy_o(busy),
    .free_o(bus_free_o)
  );

  i2c_sda_hold_drv #(.HOLD_CYC(HOLD_CYC)) i_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (filt[1]),
    .busy_i  (busy),
    .tx_en_i (tx_en_i),
    .tx_bit_i(tx_bit_i),
    .sda_oe_o(sda_oe_o)
  );

  assign scl_o       = filt[1];
  assign sda_o       = filt[0];
  assign start_o     = evt.start;
  assign rep_start_o = evt.rstart;
  assign stop_o      = evt.stop;
  assign bit_valid_o = evt.bit_vld;
  assign bit_o       = evt.bit_val;
  assign bus_busy_o  = busy;
endmodule

// File: rtl/i2c_bus_front_chk.sv
`timescale 1ns/1ps
module i2c_bus_front_chk #(
  parameter int unsigned HOLD_CYC = 38
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_o,
  input logic sda_o,
  input logic sda_oe_o,
  input logic start_o,
  input logic rep_start_o,
  input logic stop_o,
  input logic bit_valid_o,
  input logic bus_busy_o,
  input logic bus_free_o
);
  localparam int unsigned SW = $clog2(HOLD_CYC + 3) + 1;

  logic          prev_scl_q;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_scl_q <= 1'b1;
      since_q    <= '1;
    end else begin
      prev_scl_q <= scl_o;
      if (prev_scl_q && !scl_o) since_q <= SW'(1);
      else if (since_q != '1)   since_q <= since_q + 1'b1;
    end
  end

  a_r1_start_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> scl_o && !sda_o);
  a_r1_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> bus_busy_o);
  a_r2_stop_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> scl_o && sda_o);
  a_r2_stop_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !bus_busy_o);
  a_r3_rep_inside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_start_o |-> start_o && bus_busy_o);
  a_r4_strobe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> scl_o && !$past(scl_o) && bus_busy_o);
  a_r6_free_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !bus_free_o);
  a_r7_oe_stable_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && bus_busy_o && $past(bus_busy_o)) |-> $stable(sda_oe_o));
  a_r7_oe_hold_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_busy_o && $past(bus_busy_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> (since_q > SW'(HOLD_CYC)));
  a_r9_oe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_busy_o && $past(!bus_busy_o)) |-> !sda_oe_o);
endmodule

bind i2c_bus_front i2c_bus_front_chk #(.HOLD_CYC(HOLD_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_o      (scl_o),
  .sda_o      (sda_o),
  .sda_oe_o   (sda_oe_o),
  .start_o    (start_o),
  .rep_start_o(rep_start_o),
  .stop_o     (stop_o),
  .bit_valid_o(bit_valid_o),
  .bus_busy_o (bus_busy_o),
  .bus_free_o (bus_free_o)
);

// File: tb/test_i2c_bus_front.sv
`timescale 1ns/1ps
module test_i2c_bus_front;
  localparam int FILT = (50 + 7) / 8;
  localparam int HOLD = (300 + 7) / 8;
  localparam int IDLE = (1300 + 7) / 8;
  localparam int PH   = 30;

  logic clk_i = 1'b0;
  logic rst_ni, m_scl, m_sda, tx_en, tx_bit, sda_line;
  logic sda_oe_o, scl_o, sda_o, start_o, rep_start_o, stop_o;
  logic bit_valid_o, bit_o, bus_busy_o, bus_free_o;

  int checks = 0, fails = 0;
  int n_start = 0, n_rep = 0, n_stop = 0, n_bits = 0;
  logic [7:0] shreg = '0;
  logic oe_seen = 1'b0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;
  assign sda_line = m_sda & ~sda_oe_o;

  i2c_bus_front i_i2c_bus_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .tx_en_i(tx_en), .tx_bit_i(tx_bit), .sda_oe_o(sda_oe_o),
    .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .rep_start_o(rep_start_o),
    .stop_o(stop_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o),
    .bus_busy_o(bus_busy_o), .bus_free_o(bus_free_o)
  );

  always @(negedge clk_i) if (rst_ni) begin
    if (start_o)     n_start++;
    if (rep_start_o) n_rep++;
    if (stop_o)      n_stop++;
    if (bit_valid_o) begin n_bits++; shreg = {shreg[6:0], bit_o}; end
    if (sda_oe_o)    oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b);
    m_scl = 1'b0; wt(PH); m_sda = b; wt(PH); m_scl = 1'b1; wt(2*PH);
  endtask

  task automatic t_reset();
    chk(!sda_oe_o && !start_o && !stop_o && !bit_valid_o && !bus_busy_o,
        "R10 outputs idle", {sda_oe_o, bus_busy_o}, 0);
    chk(scl_o && sda_o, "R10 filtered lines high", {scl_o, sda_o}, 3);
    chk(!bus_free_o, "R6 free low after reset", bus_free_o, 0);
    wt(IDLE + 10);
    chk(bus_free_o, "R6 free after idle time", bus_free_o, 1);
  endtask

  task automatic t_idle_ignore();
    oe_seen = 1'b0; tx_en = 1'b1; tx_bit = 1'b0;
    wt(100);
    chk(!oe_seen, "R9 no pull while idle", oe_seen, 0);
    tx_en = 1'b0;
  endtask

  task automatic t_spike_idle();
    int s0 = n_start;
    m_sda = 1'b0; wt(FILT - 1); m_sda = 1'b1; wt(30);
    chk(n_start == s0, "R5 sda spike no start", n_start - s0, 0);
    m_scl = 1'b0; wt(FILT - 1); m_scl = 1'b1; wt(30);
    chk(bus_free_o, "R5 scl spike keeps free", bus_free_o, 1);
  endtask

  task automatic t_start();
    int s0 = n_start, r0 = n_rep;
    m_sda = 1'b0; wt(2*PH);
    chk(n_start == s0 + 1, "R1 start pulse", n_start - s0, 1);
    chk(n_rep == r0, "R3 first start not repeated", n_rep - r0, 0);
    chk(bus_busy_o, "R1 busy set", bus_busy_o, 1);
    chk(!bus_free_o, "R6 free dropped", bus_free_o, 0);
  endtask

  task automatic t_byte(input logic [7:0] d);
    int b0 = n_bits;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    chk(n_bits == b0 + 8, "R4 eight strobes", n_bits - b0, 8);
    chk(shreg == d, "R4 byte value", shreg, d);
  endtask

  task automatic t_ack();
    m_sda = 1'b1; tx_en = 1'b1; tx_bit = 1'b0;
    m_scl = 1'b0;
    wt(FILT + HOLD + 3);
    chk(!sda_oe_o, "R7 held before hold end", sda_oe_o, 0);
    wt(1);
    chk(sda_oe_o, "R7 applied after hold", sda_oe_o, 1);
    wt(2*PH - FILT - HOLD - 4);
    m_scl = 1'b1; wt(PH);
    chk(!sda_line, "R8 ack pulls low", sda_line, 0);
    chk(bit_o == 1'b0, "R4 ack bit sampled", bit_o, 0);
    wt(PH);
    m_scl = 1'b0; tx_en = 1'b0; wt(PH);
    chk(sda_oe_o, "R7 release waits for hold", sda_oe_o, 1);
    wt(PH);
    chk(!sda_oe_o, "R7 release after hold", sda_oe_o, 0);
  endtask

  task automatic t_scl_spike();
    int b0 = n_bits;
    m_scl = 1'b1; wt(FILT - 1); m_scl = 1'b0; wt(PH);
    chk(n_bits == b0, "R5 scl spike no strobe", n_bits - b0, 0);
  endtask

  task automatic t_read_one();
    oe_seen = 1'b0; tx_en = 1'b1; tx_bit = 1'b1;
    send_bit(1'b1);
    chk(!oe_seen, "R8 high bit releases", oe_seen, 0);
    chk(shreg[0] == 1'b1, "R4 read bit sampled", shreg[0], 1);
    tx_en = 1'b0;
  endtask

  task automatic t_rep_start();
    int s0 = n_start, r0 = n_rep, b0 = n_bits;
    m_scl = 1'b0; wt(PH); m_sda = 1'b1; wt(PH);
    m_scl = 1'b1; wt(2*PH); m_sda = 1'b0; wt(2*PH);
    chk(n_rep == r0 + 1, "R3 repeated start flagged", n_rep - r0, 1);
    chk(n_start == s0 + 1, "R1 repeated start pulse", n_start - s0, 1);
    chk(n_bits == b0 + 1, "R4 one strobe before restart", n_bits - b0, 1);
  endtask

  task automatic t_sda_spike_high();
    int p0 = n_stop, s0 = n_start;
    m_sda = 1'b1; wt(FILT - 1); m_sda = 1'b0; wt(20);
    chk(n_stop == p0 && n_start == s0, "R5 sda spike no stop", n_stop - p0, 0);
    chk(bus_busy_o, "R5 transfer still open", bus_busy_o, 1);
  endtask

  task automatic t_stop();
    int p0 = n_stop;
    m_scl = 1'b0; wt(PH); m_sda = 1'b0; wt(PH);
    m_scl = 1'b1; wt(2*PH); m_sda = 1'b1; wt(20);
    chk(n_stop == p0 + 1, "R2 stop pulse", n_stop - p0, 1);
    chk(!bus_busy_o, "R2 busy cleared", bus_busy_o, 0);
    chk(!bus_free_o, "R6 not free yet", bus_free_o, 0);
    chk(!sda_oe_o, "R9 released after stop", sda_oe_o, 0);
    wt(IDLE);
    chk(bus_free_o, "R6 free after stop", bus_free_o, 1);
  endtask

  initial begin
    m_scl = 1'b1; m_sda = 1'b1; tx_en = 1'b0; tx_bit = 1'b0; rst_ni = 1'b0;
    wt(5);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle_ignore();
    t_spike_idle();
    t_start();
    t_byte(8'hA5);
    t_ack();
    t_scl_spike();
    t_read_one();
    t_rep_start();
    t_byte(8'h3C);
    t_sda_spike_high();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule